// File: doc/BRIEF.md
# Packet Halfword Receive Channel

This block takes packets arriving as a stream of 16-bit halfwords on a simple strobe/acknowledge link and lays them down in memory. The first halfword of each packet is its length in halfwords. If the channel accepts the length, it takes the buffer at the head of a free-buffer queue. It overwrites that buffer's header word with the length. It then packs the following halfwords two to a 36-bit word in the words that follow the header. Once the last halfword is stored, the buffer address is pushed to a done queue.

Length halfwords that are zero, or that exceed the capacity of the waiting buffer, are acknowledged and thrown away. This lets the channel fall back into step with a sender that restarted mid-packet. When a real packet arrives and no free buffer is waiting, the channel disarms itself and leaves the halfword untaken. A one-cycle wake pulse arms it again.

Data halfwords are stored in 18-bit slots with two zero pad bits, in the layout `{2'b00, first, 2'b00, second}`. A header word and an odd trailing halfword use the upper slot only: `{2'b00, value, 18'b0}`.

Top module: `rxch_top`

## Requirements
- R1: After reset, `mem_we` and `done_vld` are low and the channel is disarmed.
- R2: While disarmed and no packet is in progress, a presented halfword is not taken (`lnk_take` low). After a `wake` pulse, the next length halfword is taken.
- R3: A zero length halfword is taken in the cycle it is presented. It pops no buffer, causes no write, and the next halfword is again treated as a length.
- R4: A length greater than `fq_cap` is taken and discarded, with no pop and no write. A length equal to `fq_cap` is accepted.
- R5: A nonzero length presented while armed with `fq_vld` low is not taken, and the channel disarms. It takes no later length, even after a buffer appears, until `wake` is pulsed.
- R6: On acceptance, `fq_pop` is high in the take cycle. In the next cycle a write goes to `fq_addr` with data `{2'b00, length, 18'b0}`.
- R7: Data halfwords at even positions (first, third, ...) cause no write. Each odd-position halfword produces, one cycle after its take, one write of `{2'b00, held, 2'b00, this}` at buffer address + 1 + pair index.
- R8: When the packet length is odd, its last halfword is written alone as `{2'b00, last, 18'b0}` one cycle after its take, at the next word.
- R9: `done_vld` pulses for one cycle, together with the packet's final data write, with `done_addr` equal to the buffer address. The next halfword is then treated as a length.
- R10: `lnk_take` is high only while `lnk_vld` is high, and every data halfword of an accepted packet is taken in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake | input | 1 | One-cycle pulse that arms the channel |
| lnk_vld | input | 1 | Link halfword present |
| lnk_data | input | 16 | Link halfword |
| lnk_take | output | 1 | Halfword consumed this cycle |
| fq_vld | input | 1 | Free-buffer queue has an entry |
| fq_addr | input | AW | Word address of the free buffer's header |
| fq_cap | input | 16 | Capacity of that buffer in halfwords |
| fq_pop | output | 1 | Remove the head free buffer |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write word address |
| mem_wdata | output | 36 | Memory write data |
| done_vld | output | 1 | Push a filled buffer to the done queue |
| done_addr | output | AW | Address of the filled buffer |

## Verification
The final data write of a packet and the push to the done queue land in the same cycle. For odd lengths, that write is the solo flush of the last halfword. The scoreboard provokes this with packets of length 4, 3, 1 and 2. Each expected write carries a done flag and an address, and the monitor compares `done_vld` and `done_addr` against those fields on the very cycle of the write. A done pulse without a write, or a write without the expected done, is reported. A second overlap, where the disarm and a buffer becoming free meet, is provoked by adding a buffer right after a starved length and checking that the length is still refused until a wake.

// File: rtl/rxch_pkg.sv
package rxch_pkg;

    localparam int HALF_W = 16;
    localparam int SLOT_W = 18;
    localparam int WORD_W = 2 * SLOT_W;
    localparam int PAD_W  = SLOT_W - HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    // What the presented halfword means this cycle
    typedef enum logic [2:0] {
        XK_IDLE,    // nothing presented or not eligible
        XK_ZERO,    // zero length, consumed and dropped
        XK_OVER,    // length beyond buffer capacity, consumed and dropped
        XK_STARVE,  // no free buffer, not consumed, channel disarms
        XK_ACCEPT,  // length accepted, buffer claimed
        XK_DATA     // payload halfword of the packet in progress
    } xfer_kind_e;

    function automatic word_t pack_pair(half_t hi, half_t lo);
        return {{PAD_W{1'b0}}, hi, {PAD_W{1'b0}}, lo};
    endfunction

    function automatic word_t pack_upper(half_t hi);
        return pack_pair(hi, '0);
    endfunction

    function automatic logic is_consumed(xfer_kind_e k);
        return (k == XK_ZERO) || (k == XK_OVER) || (k == XK_ACCEPT) || (k == XK_DATA);
    endfunction

endpackage

// File: rtl/rxch_classify.sv
module rxch_classify
    import rxch_pkg::*;
(
    input  logic       lnk_vld,
    input  half_t      lnk_data,
    input  logic       busy,
    input  logic       armed,
    input  logic       fq_vld,
    input  half_t      fq_cap,
    output xfer_kind_e kind,
    output logic       take,
    output logic       pop
);

    always_comb begin
        kind = XK_IDLE;
        if (lnk_vld) begin
            if (busy) begin
                kind = XK_DATA;
            end else if (armed) begin
                if (lnk_data == '0) begin
                    kind = XK_ZERO;
                end else if (!fq_vld) begin
                    kind = XK_STARVE;
                end else if (lnk_data > fq_cap) begin
                    kind = XK_OVER;
                end else begin
                    kind = XK_ACCEPT;
                end
            end
        end
    end

    assign take = is_consumed(kind);
    assign pop  = (kind == XK_ACCEPT);

endmodule

// File: rtl/rxch_arm.sv
module rxch_arm
    import rxch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wake,
    input  xfer_kind_e kind,
    output logic       armed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (wake) begin
            armed <= 1'b1;
        end else if (kind == XK_STARVE) begin
            armed <= 1'b0;
        end
    end

    // R2: arming only comes from a wake pulse
    a_r2_arm_needs_wake: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(wake));

endmodule

// File: rtl/rxch_packer.sv
module rxch_packer
    import rxch_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_kind_e    kind,
    input  half_t         data,
    input  logic [AW-1:0] fq_addr,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output word_t         mem_wdata,
    output logic          done_vld,
    output logic [AW-1:0] done_addr
);

    localparam logic [HALF_W-1:0] ONE_LEFT = HALF_W'(1);
    localparam logic [AW-1:0]     ADDR_ONE = AW'(1);

    half_t         cnt;
    half_t         held;
    logic          phase;   // 1: a halfword is held awaiting its partner
    logic [AW-1:0] wptr;
    logic [AW-1:0] base;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            held      <= '0;
            phase     <= 1'b0;
            wptr      <= '0;
            base      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done_vld  <= 1'b0;
            done_addr <= '0;
        end else begin
            mem_we   <= 1'b0;
            done_vld <= 1'b0;
            case (kind)
                XK_ACCEPT: begin
                    busy      <= 1'b1;
                    cnt       <= data;
                    phase     <= 1'b0;
                    base      <= fq_addr;
                    wptr      <= fq_addr + ADDR_ONE;
                    mem_we    <= 1'b1;
                    mem_addr  <= fq_addr;
                    mem_wdata <= pack_upper(data);
                end
                XK_STARVE: begin
                    cnt <= '0;
                end
                XK_DATA: begin
                    cnt <= cnt - ONE_LEFT;
                    if (!phase) begin
                        held  <= data;
                        phase <= 1'b1;
                        if (cnt == ONE_LEFT) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= wptr;
                            mem_wdata <= pack_upper(data);
                        end
                    end else begin
                        phase     <= 1'b0;
                        wptr      <= wptr + ADDR_ONE;
                        mem_we    <= 1'b1;
                        mem_addr  <= wptr;
                        mem_wdata <= pack_pair(held, data);
                    end
                    if (cnt == ONE_LEFT) begin
                        busy      <= 1'b0;
                        done_vld  <= 1'b1;
                        done_addr <= base;
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: a completed buffer is posted only alongside its last write
    a_r9_done_with_write: assert property (@(posedge clk) disable iff (rst)
        done_vld |-> mem_we);

    // R9: leaving a packet always posts it
    a_r9_end_posts: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_vld);

    // R6: the header write goes out as the packet starts
    a_r6_header_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_we && mem_addr == base));

    // R7: the held partner never survives past the end of a packet
    a_r7_no_stale_half: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(phase && cnt != '0));

endmodule

// File: rtl/rxch_top.sv
module rxch_top
    import rxch_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wake,
    input  logic          lnk_vld,
    input  logic [15:0]   lnk_data,
    output logic          lnk_take,
    input  logic          fq_vld,
    input  logic [AW-1:0] fq_addr,
    input  logic [15:0]   fq_cap,
    output logic          fq_pop,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [35:0]   mem_wdata,
    output logic          done_vld,
    output logic [AW-1:0] done_addr
);

    xfer_kind_e kind;
    logic       busy;
    logic       armed;

    rxch_classify u_classify (
        .lnk_vld  (lnk_vld),
        .lnk_data (lnk_data),
        .busy     (busy),
        .armed    (armed),
        .fq_vld   (fq_vld),
        .fq_cap   (fq_cap),
        .kind     (kind),
        .take     (lnk_take),
        .pop      (fq_pop)
    );

    rxch_arm u_arm (
        .clk   (clk),
        .rst   (rst),
        .wake  (wake),
        .kind  (kind),
        .armed (armed)
    );

    rxch_packer #(.AW(AW)) u_packer (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .data      (lnk_data),
        .fq_addr   (fq_addr),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done_vld  (done_vld),
        .done_addr (done_addr)
    );

    // R10: nothing is acknowledged unless presented
    a_r10_take_needs_vld: assert property (@(posedge clk) disable iff (rst)
        lnk_take |-> lnk_vld);

    // R3: a zero length never claims a buffer
    a_r3_zero_no_pop: assert property (@(posedge clk) disable iff (rst)
        (lnk_vld && !busy && lnk_data == '0) |-> !fq_pop);

    // R5: without a free buffer, a length is never consumed
    a_r5_starve_no_take: assert property (@(posedge clk) disable iff (rst)
        (lnk_vld && !busy && lnk_data != '0 && !fq_vld) |-> !lnk_take);

    // R6: a pop only happens when an entry exists and the length is taken
    a_r6_pop_with_take: assert property (@(posedge clk) disable iff (rst)
        fq_pop |-> (fq_vld && lnk_take));

endmodule

// File: tb/rxch_top_tb_top.sv
module rxch_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;

    typedef struct {
        logic [AW-1:0] addr;
        logic [35:0]   data;
        logic          done;
        logic [AW-1:0] done_addr;
        string         tag;
    } exp_t;

    typedef struct {
        logic [AW-1:0] addr;
        logic [15:0]   cap;
    } fbuf_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wake = 1'b0;
    logic          lnk_vld = 1'b0;
    logic [15:0]   lnk_data = '0;
    logic          lnk_take;
    logic          fq_vld = 1'b0;
    logic [AW-1:0] fq_addr = '0;
    logic [15:0]   fq_cap = '0;
    logic          fq_pop;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [35:0]   mem_wdata;
    logic          done_vld;
    logic [AW-1:0] done_addr;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t exp_q[$];
    fbuf_t fq_q[$];

    // reference model state
    logic          m_en = 1'b0;
    logic          m_busy = 1'b0;
    logic [15:0]   m_cnt = '0;
    logic          m_phase = 1'b0;
    logic [15:0]   m_held = '0;
    logic [AW-1:0] m_ptr = '0;
    logic [AW-1:0] m_base = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxch_top #(.AW(AW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .wake      (wake),
        .lnk_vld   (lnk_vld),
        .lnk_data  (lnk_data),
        .lnk_take  (lnk_take),
        .fq_vld    (fq_vld),
        .fq_addr   (fq_addr),
        .fq_cap    (fq_cap),
        .fq_pop    (fq_pop),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done_vld  (done_vld),
        .done_addr (done_addr)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply_fq();
        fq_vld  = (fq_q.size() > 0);
        fq_addr = (fq_q.size() > 0) ? fq_q[0].addr : '0;
        fq_cap  = (fq_q.size() > 0) ? fq_q[0].cap  : '0;
    endtask

    task automatic add_buf(input logic [AW-1:0] a, input logic [15:0] c);
        fbuf_t b;
        b.addr = a;
        b.cap  = c;
        fq_q.push_back(b);
        apply_fq();
    endtask

    task automatic expect_wr(input logic [AW-1:0] a, input logic [35:0] d,
                             input logic dn, input string tag);
        exp_t e;
        e.addr = a;
        e.data = d;
        e.done = dn;
        e.done_addr = m_base;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_wake();
        @(negedge clk);
        wake = 1'b1;
        @(posedge clk);
        #1 wake = 1'b0;
        m_en = 1'b1;
    endtask

    // driver: model the expected reaction, then present the halfword
    task automatic send(input logic [15:0] d, input string tag);
        logic et;
        logic ep;
        et = 1'b0;
        ep = 1'b0;
        if (m_busy) begin
            et = 1'b1;
            m_cnt = m_cnt - 16'd1;
            if (!m_phase) begin
                m_held  = d;
                m_phase = 1'b1;
                if (m_cnt == 0) expect_wr(m_ptr, {2'b00, d, 18'd0}, 1'b1, "R8");
            end else begin
                expect_wr(m_ptr, {2'b00, m_held, 2'b00, d}, (m_cnt == 0), "R7");
                m_ptr   = m_ptr + 1'b1;
                m_phase = 1'b0;
            end
            if (m_cnt == 0) m_busy = 1'b0;
        end else if (m_en) begin
            if (d == 0) begin
                et = 1'b1;
            end else if (fq_q.size() == 0) begin
                m_en = 1'b0;
            end else if (d > fq_q[0].cap) begin
                et = 1'b1;
            end else begin
                et = 1'b1;
                ep = 1'b1;
                m_base  = fq_q[0].addr;
                expect_wr(fq_q[0].addr, {2'b00, d, 18'd0}, 1'b0, "R6");
                m_busy  = 1'b1;
                m_cnt   = d;
                m_ptr   = fq_q[0].addr + 1'b1;
                m_phase = 1'b0;
            end
        end
        @(negedge clk);
        apply_fq();
        lnk_vld  = 1'b1;
        lnk_data = d;
        #1;
        check(lnk_take == et, tag, "lnk_take", 64'(lnk_take), 64'(et));
        check(fq_pop == ep, tag, "fq_pop", 64'(fq_pop), 64'(ep));
        @(posedge clk);
        if (ep) void'(fq_q.pop_front());
        #1;
        lnk_vld = 1'b0;
        apply_fq();
    endtask

    // monitor: compare each write and done push against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected write", 64'(mem_addr), 64'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.addr, e.tag, "mem_addr", 64'(mem_addr), 64'(e.addr));
                    check(mem_wdata == e.data, e.tag, "mem_wdata", 64'(mem_wdata), 64'(e.data));
                    check(done_vld == e.done, "R9", "done_vld", 64'(done_vld), 64'(e.done));
                    if (e.done)
                        check(done_addr == e.done_addr, "R9", "done_addr",
                              64'(done_addr), 64'(e.done_addr));
                end
            end else if (done_vld) begin
                check(1'b0, "R9", "done without write", 64'(done_addr), 64'(0));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(mem_we == 1'b0, "R1", "mem_we", 64'(mem_we), 64'(0));
        check(done_vld == 1'b0, "R1", "done_vld", 64'(done_vld), 64'(0));

        // R1/R2: disarmed, a length is left untaken
        send(16'd5, "R2");
        do_wake();
        add_buf(18'h100, 16'd8);
        add_buf(18'h200, 16'd3);
        add_buf(18'h300, 16'd8);

        // R6, R7, R9: even length, two packed words, done with the last
        send(16'd4, "R6");
        send(16'h00A1, "R10");
        send(16'h00B2, "R7");
        send(16'h00C3, "R10");
        send(16'h00D4, "R9");

        // R4 boundary: length equal to capacity; R8 odd trailing flush
        send(16'd3, "R4");
        send(16'h1111, "R10");
        send(16'h2222, "R7");
        send(16'h3333, "R8");

        // R3: zero length dropped; R4: oversize dropped
        send(16'd0, "R3");
        send(16'd9, "R4");
        // single-halfword packet: flush alone with done
        send(16'd1, "R6");
        send(16'hEEEE, "R8");

        // R5: starve, disarm, stays refused after a buffer appears
        send(16'd2, "R5");
        add_buf(18'h400, 16'd8);
        send(16'd2, "R5");
        do_wake();
        send(16'd2, "R2");
        send(16'h5555, "R10");
        send(16'hAAAA, "R9");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending writes", 64'(exp_q.size()), 64'(0));
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule